// File: doc/BRIEF.md
# Primary Clock Loss Monitor with Failover Select

This block supervises a primary clock using a backup clock as its timebase. When the primary stops producing rising edges for long enough, it raises a loss flag and drives a one-bit select that steers a downstream clock multiplexer to the backup. As soon as the primary toggles again, the flag drops and the select returns to the primary. There is no hold-off period on the way back.

Activity is detected by a flop that toggles on every primary rising edge. That toggle is carried into the backup domain through a synchronizer, and each change seen there clears a saturating counter of backup periods. A timeout-select input chooses the short limit of 3 periods or the long limit of 48. A manual override lets the select follow a direct choice input while the loss flag keeps monitoring. The timeout-select and choice inputs are registered. While reset is held, their registers take parameterised tie-off values that default to high.

The primary must produce a rising edge at least once every two backup periods while it is running. If it runs slower than that, the short limit can report a loss.

Top module: `clkmon_failover`

## Requirements
- R1: loss_flag stays low while the primary runs. Once the primary stops, loss_flag rises between LIM+3 and LIM+5 backup rising edges after the last primary rising edge, where LIM is the selected limit.
- R2: With long_tmo low, the limit LIM is 3 backup periods.
- R3: With long_tmo high, the limit LIM is 48 backup periods.
- R4: In automatic mode (man_mode low), clk_sel encodes 1 = primary and 0 = backup. clk_sel goes to 0 on the backup edge after loss_flag rises, and to 1 on the backup edge after loss_flag falls.
- R5: After the primary restarts, loss_flag falls within 4 backup rising edges of the first primary rising edge. No timeout is applied on recovery.
- R6: With man_mode high, clk_sel equals man_pick (1 = primary, 0 = backup) within 2 backup edges, whatever the loss state. loss_flag keeps tracking the primary in this mode.
- R7: rst is synchronous and active high on bak_clk. While rst is held and after it is released, loss_flag is 0 and clk_sel is 1 until a timeout occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pri_clk | input | 1 | Primary clock being monitored |
| bak_clk | input | 1 | Backup clock; timebase of the monitor |
| rst | input | 1 | Synchronous active-high reset |
| long_tmo | input | 1 | Timeout select: 0 = 3 periods, 1 = 48 periods |
| man_mode | input | 1 | 1 = select follows man_pick |
| man_pick | input | 1 | Manual choice: 1 = primary, 0 = backup |
| loss_flag | output | 1 | High while the primary is deemed lost |
| clk_sel | output | 1 | Multiplexer select: 1 = primary, 0 = backup |

## Verification
The bench sweeps both timeout settings across two primary periods and several stop and restart phases. In each case it counts backup edges from the last primary edge to the flag rising. A counter that cleared late, compared off by one, or used the wrong limit falls outside the window. A detector that mistook slow sampling for loss would raise the flag while the primary still runs. On restart, the edge count exposes any design that waits for a timeout before dropping the flag. The manual checks confirm that the override wins over a live loss, that the flag keeps tracking underneath, and that leaving manual mode hands the select back to the flag.

// File: rtl/clkmon_pkg.sv
package clkmon_pkg;
  // select encoding seen by the downstream clock multiplexer
  localparam logic SEL_PRIMARY = 1'b1;
  localparam logic SEL_BACKUP  = 1'b0;

  function automatic int cnt_width(input int max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction
endpackage

// File: rtl/clkmon_toggle.sv
module clkmon_toggle (
  input  logic pri_clk,
  input  logic pri_rst,
  output logic tog
);
  // only the changes of tog carry meaning, its absolute level does not
  always_ff @(posedge pri_clk) begin
    if (pri_rst) tog <= 1'b0;
    else         tog <= ~tog;
  end
endmodule

// File: rtl/clkmon_sync.sv
module clkmon_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[0] <= 1'b0;
        else     chain[0] <= d;
      end
    end else begin : g_rest
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= 1'b0;
        else     chain[i] <= chain[i-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/clkmon_timer.sv
module clkmon_timer #(
  parameter int SHORT_LIMIT = 3,
  parameter int LONG_LIMIT  = 48,
  parameter int CW          = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tog_s,
  input  logic          long_sel,
  output logic          act,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] lim,
  output logic          loss
);
  localparam logic [CW-1:0] SHORT_L = CW'(SHORT_LIMIT);
  localparam logic [CW-1:0] LONG_L  = CW'(LONG_LIMIT);
  localparam logic [CW-1:0] SAT_L   = (LONG_LIMIT > SHORT_LIMIT) ? LONG_L : SHORT_L;

  logic prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= tog_s;
  end

  assign act = tog_s ^ prev;
  assign lim = long_sel ? LONG_L : SHORT_L;

  // idle-period counter: cleared by activity, saturating at the larger limit
  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (act)         cnt <= '0;
    else if (cnt < SAT_L) cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)      loss <= 1'b0;
    else if (act) loss <= 1'b0;
    else          loss <= (cnt >= lim);
  end
endmodule

// File: rtl/clkmon_failover.sv
module clkmon_failover
  import clkmon_pkg::*;
#(
  parameter int   SHORT_LIMIT = 3,
  parameter int   LONG_LIMIT  = 48,
  parameter int   SYNC_STAGES = 2,
  parameter logic TMO_TIE     = 1'b1,
  parameter logic PICK_TIE    = 1'b1
) (
  input  logic pri_clk,
  input  logic bak_clk,
  input  logic rst,
  input  logic long_tmo,
  input  logic man_mode,
  input  logic man_pick,
  output logic loss_flag,
  output logic clk_sel
);
  localparam int CW = cnt_width((LONG_LIMIT > SHORT_LIMIT) ? LONG_LIMIT : SHORT_LIMIT);

  logic          tog;
  logic          tog_s;
  logic          act;
  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;
  logic          long_q;
  logic          mode_q;
  logic          pick_q;

  // configuration capture; reset loads the tie-off levels
  always_ff @(posedge bak_clk) begin
    if (rst) begin
      long_q <= TMO_TIE;
      pick_q <= PICK_TIE;
      mode_q <= 1'b0;
    end else begin
      long_q <= long_tmo;
      pick_q <= man_pick;
      mode_q <= man_mode;
    end
  end

  clkmon_toggle u_tog (
    .pri_clk (pri_clk),
    .pri_rst (rst),
    .tog     (tog)
  );

  clkmon_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (bak_clk),
    .rst (rst),
    .d   (tog),
    .q   (tog_s)
  );

  clkmon_timer #(
    .SHORT_LIMIT (SHORT_LIMIT),
    .LONG_LIMIT  (LONG_LIMIT),
    .CW          (CW)
  ) u_timer (
    .clk      (bak_clk),
    .rst      (rst),
    .tog_s    (tog_s),
    .long_sel (long_q),
    .act      (act),
    .cnt      (cnt),
    .lim      (lim),
    .loss     (loss_flag)
  );

  always_ff @(posedge bak_clk) begin
    if (rst)         clk_sel <= SEL_PRIMARY;
    else if (mode_q) clk_sel <= pick_q ? SEL_PRIMARY : SEL_BACKUP;
    else             clk_sel <= loss_flag ? SEL_BACKUP : SEL_PRIMARY;
  end
endmodule

// File: rtl/clkmon_failover_chk.sv
module clkmon_failover_chk #(
  parameter int CW = 6
) (
  input logic          bak_clk,
  input logic          rst,
  input logic          loss_flag,
  input logic          clk_sel,
  input logic          mode_q,
  input logic          pick_q,
  input logic          act,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] lim
);
  AST_RESET_STATE: assert property (@(posedge bak_clk)
    rst |=> (!loss_flag && clk_sel)); // R7

  AST_LOSS_AFTER_LIMIT: assert property (@(posedge bak_clk) disable iff (rst)
    $rose(loss_flag) |-> ($past(cnt) >= $past(lim))); // R1

  AST_AUTO_SELECT: assert property (@(posedge bak_clk) disable iff (rst)
    !mode_q |=> (clk_sel == !$past(loss_flag))); // R4

  AST_MANUAL_SELECT: assert property (@(posedge bak_clk) disable iff (rst)
    mode_q |=> (clk_sel == $past(pick_q))); // R6

  AST_ACTIVITY_CLEARS: assert property (@(posedge bak_clk) disable iff (rst)
    act |=> !loss_flag); // R5
endmodule

bind clkmon_failover clkmon_failover_chk #(.CW(CW)) u_chk (
  .bak_clk   (bak_clk),
  .rst       (rst),
  .loss_flag (loss_flag),
  .clk_sel   (clk_sel),
  .mode_q    (mode_q),
  .pick_q    (pick_q),
  .act       (act),
  .cnt       (cnt),
  .lim       (lim)
);

// File: tb/clkmon_failover_bench.sv
`timescale 1ns/1ps
module clkmon_failover_bench;
  logic pri_clk, bak_clk, rst;
  logic long_tmo, man_mode, man_pick;
  logic loss_flag, clk_sel;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;
  bit pri_run = 1'b1;
  realtime pri_half = 3.45;

  clkmon_failover u_clkmon_failover (
    .pri_clk   (pri_clk),
    .bak_clk   (bak_clk),
    .rst       (rst),
    .long_tmo  (long_tmo),
    .man_mode  (man_mode),
    .man_pick  (man_pick),
    .loss_flag (loss_flag),
    .clk_sel   (clk_sel)
  );

  initial begin
    bak_clk = 1'b0;
    forever #2 bak_clk = ~bak_clk;
  end

  initial begin
    pri_clk = 1'b0;
    forever begin
      #(pri_half);
      if (pri_run) pri_clk = ~pri_clk;
    end
  end

  task automatic chk(input string tag, input int actual, input int expected);
    total++;
    if (actual != expected) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
    end
  endtask

  task automatic chk_range(input string tag, input int actual, input int lo, input int hi);
    total++;
    if (actual < lo || actual > hi) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", tag, actual, lo, hi);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge bak_clk);
  endtask

  initial begin
    #400000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n;
    int lim;
    int seen_high;
    rst = 1'b1; long_tmo = 1'b1; man_mode = 1'b0; man_pick = 1'b1;
    cycles(6);
    chk("R7 loss during reset", loss_flag, 0);
    chk("R7 sel during reset", clk_sel, 1);
    rst = 1'b0;
    cycles(20);
    chk("R7 loss after reset", loss_flag, 0);
    chk("R7 sel after reset", clk_sel, 1);

    // sweep timeout setting x primary period x stop/restart phase
    for (int t = 0; t < 2; t++) begin
      for (int p = 0; p < 2; p++) begin
        for (int ph = 0; ph < 3; ph++) begin
          lim = (t == 1) ? 48 : 3;
          @(negedge bak_clk);
          long_tmo = t[0];
          pri_half = (p == 0) ? 2.55 : 3.45;
          pri_run  = 1'b1;
          seen_high = 0;
          for (int i = 0; i < lim + 12; i++) begin
            @(negedge bak_clk);
            if (loss_flag) seen_high = 1;
          end
          chk("R1 no loss while primary runs", seen_high, 0);

          #(ph * 1.3);
          @(posedge pri_clk);
          pri_run = 1'b0;
          n = 0;
          for (int i = 0; i < 100; i++) begin
            @(posedge bak_clk);
            n++;
            @(negedge bak_clk);
            if (loss_flag) break;
          end
          if (t == 0) chk_range("R2 R1 short timeout edges", n, lim + 3, lim + 5);
          else        chk_range("R3 R1 long timeout edges", n, lim + 3, lim + 5);
          @(negedge bak_clk);
          chk("R4 sel to backup after loss", clk_sel, 0);
          cycles(4);
          chk("R1 loss holds while stopped", loss_flag, 1);

          #(ph * 0.7);
          pri_run = 1'b1;
          @(posedge pri_clk);
          n = 0;
          for (int i = 0; i < 20; i++) begin
            @(posedge bak_clk);
            n++;
            @(negedge bak_clk);
            if (!loss_flag) break;
          end
          chk_range("R5 recovery edges", n, 1, 4);
          @(negedge bak_clk);
          chk("R4 sel back to primary", clk_sel, 1);
        end
      end
    end

    // manual override
    @(negedge bak_clk);
    long_tmo = 1'b0;
    man_mode = 1'b1;
    man_pick = 1'b0;
    cycles(2);
    chk("R6 manual pick backup with primary live", clk_sel, 0);
    chk("R6 loss low with primary live", loss_flag, 0);
    man_pick = 1'b1;
    cycles(2);
    chk("R6 manual pick primary", clk_sel, 1);
    @(posedge pri_clk);
    pri_run = 1'b0;
    cycles(15);
    chk("R6 loss tracks in manual mode", loss_flag, 1);
    chk("R6 manual primary overrides loss", clk_sel, 1);
    man_pick = 1'b0;
    cycles(2);
    chk("R6 manual pick backup with loss", clk_sel, 0);
    man_pick = 1'b1;
    man_mode = 1'b0;
    cycles(3);
    chk("R4 auto mode follows loss", clk_sel, 0);
    pri_run = 1'b1;
    cycles(8);
    chk("R5 loss clears after manual exit", loss_flag, 0);
    chk("R4 auto sel back to primary", clk_sel, 1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule